// File: doc/BRIEF.md
# Serial ADC Control Word and Channel Sequencer

This block is the host-facing digital front end of an eight-input sampling converter. The host opens a frame by pulling chip select low and clocks sixteen bits on falling serial-clock edges. Each frame carries a control word from host to block on the data input. In the same frame, the block returns a tagged result on the data output: a 4-bit source address followed by a 12-bit sample.

The stored control word does several things. It picks one channel or a set of channels to convert, and it can make the converter cycle through that set over and over. It can request a temperature measurement, with or without averaging. It also drives a reference-select line and a partial power-down line.

A sequencer steps the analog mux once per frame, on the fourteenth falling edge. The conversion itself lives outside the block. The sample for the selected source arrives on a plain data input, and a done strobe marks the end of a temperature measurement. The serial lines are sampled by the system clock through two-stage synchronisers, so SCLK must be several times slower than the system clock.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, the stored control word is all zeros, and dout, busy, mux_sel, ext_ref and pwr_down are all 0.
- R2: While cs_n is low, din is shifted in MSB first on the first 16 falling sclk edges only. Any further edges in that frame change neither the stored word nor any output.
- R3: Frame bit 15 is a write enable. When it is 0, the stored word and every output derived from it keep their values.
- R4: Frame bit layout: bit 14 is repeat, bits 13..6 select channels 0..7 (bit 13 is channel 0, bit 6 is channel 7), bit 5 requests temperature, bits 4..3 are ignored, bit 2 drives ext_ref, bit 1 selects averaging and bit 0 drives pwr_down. A write takes effect after the 16th falling edge.
- R5: After a write, the next step selects the lowest chosen channel. Each later step moves to the next higher chosen channel. Past the highest one, the sequencer wraps to the lowest if repeat is set and otherwise stays where it is. With no channel chosen, mux_sel holds.
- R6: mux_sel changes only on the 14th falling sclk edge of a frame. It is unchanged after the 13th edge.
- R7: dout carries the captured 16-bit word MSB first: bits 15..12 are the tag and bits 11..0 are the sample. The first bit appears after cs_n falls and each later bit after each falling edge. At the end of every complete frame taken while not busy, the block captures conv_data tagged with the mux_sel value. Tags 0..7 are channels, 8 is temperature and 9 is averaged temperature.
- R8: A write with bit 5 set raises busy after the next cs_n falling edge. busy falls when temp_done is pulsed, and at that moment conv_data is captured with tag 8, or tag 9 if averaging is selected. While busy, frames return the previous result.
- R9: Setting the averaging bit without bit 5 never raises busy.
- R10: If cs_n rises before the 16th falling edge, the frame is dropped. No write, capture or mux step happens, and the next frame counts from zero.
- R11: pwr_down stays 1 across frames until a write clears bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Frame select, active low |
| sclk | input | 1 | Serial clock, idles high, data taken on falling edges |
| din | input | 1 | Serial control word from host |
| dout | output | 1 | Serial tagged result to host |
| conv_data | input | 12 | Sample from the external converter |
| temp_done | input | 1 | One-cycle pulse ending a temperature measurement |
| mux_sel | output | 3 | Channel selected on the analog mux |
| busy | output | 1 | Temperature measurement in progress |
| ext_ref | output | 1 | External reference selected |
| pwr_down | output | 1 | Partial power-down requested |

## Verification
The bench builds the block with its default parameters: eight channels, 12-bit samples and a 16-bit frame with the mux step on edge 14. With eight channels, the sequencer can be tested wrapping from channel 6 back to channel 1. The set {2,4} tests holding on the last channel when repeat is off. With the 4-bit tag, both temperature codes 8 and 9 appear alongside the channel codes. The 16-bit frame length makes a 20-edge frame and a 10-edge abort meaningful boundary cases.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int CH_N     = 8;
  localparam int RES_W    = 12;
  localparam int CH_W     = $clog2(CH_N);
  localparam int TAG_W    = CH_W + 1;
  localparam int OUT_W    = TAG_W + RES_W;
  localparam int CTL_W    = CH_N + 7;
  localparam int FRM_W    = CTL_W + 1;
  localparam int MUX_EDGE = FRM_W - 2;

  typedef struct packed {
    logic            rpt;
    logic [CH_N-1:0] chmap;   // MSB is channel 0
    logic            tsense;
    logic [1:0]      spare;
    logic            ext_ref;
    logic            avg;
    logic            ppd;
  } ctl_t;

  localparam logic [TAG_W-1:0] TAG_TEMP     = TAG_W'(CH_N);
  localparam logic [TAG_W-1:0] TAG_TEMP_AVG = TAG_W'(CH_N + 1);
endpackage

// File: rtl/adc_seq_spi.sv
module adc_seq_spi
  import adc_seq_pkg::*;
#(
  parameter int FW = FRM_W,
  parameter int OW = OUT_W,
  parameter int ME = MUX_EDGE
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          sclk,
  input  logic          din,
  input  logic [OW-1:0] load_word,
  output logic          dout,
  output logic          frm_start,
  output logic          frm_end,
  output logic          wr_stb,
  output logic [FW-1:0] wr_word,
  output logic          mux_stb
);
  localparam int CNT_W = $clog2(FW + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FW);
  localparam logic [CNT_W-1:0] CNT_MUX  = CNT_W'(ME - 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FW - 1);

  logic [2:0]       cs_sy, ck_sy;
  logic [1:0]       di_sy;
  logic             cs_fall, cs_rise, ck_fall, bit_in;
  logic             active;
  logic [CNT_W-1:0] cnt;
  logic [FW-2:0]    shi;
  logic [OW-1:0]    sho;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_sy <= '1;
      ck_sy <= '1;
      di_sy <= '0;
    end else begin
      cs_sy <= {cs_sy[1:0], cs_n};
      ck_sy <= {ck_sy[1:0], sclk};
      di_sy <= {di_sy[0], din};
    end
  end

  assign cs_fall = cs_sy[2] & ~cs_sy[1];
  assign cs_rise = ~cs_sy[2] & cs_sy[1];
  assign ck_fall = ck_sy[2] & ~ck_sy[1];
  assign bit_in  = di_sy[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= 1'b0;
      cnt       <= '0;
      shi       <= '0;
      sho       <= '0;
      dout      <= 1'b0;
      frm_start <= 1'b0;
      frm_end   <= 1'b0;
      wr_stb    <= 1'b0;
      wr_word   <= '0;
      mux_stb   <= 1'b0;
    end else begin
      frm_start <= 1'b0;
      frm_end   <= 1'b0;
      wr_stb    <= 1'b0;
      mux_stb   <= 1'b0;
      dout      <= active & sho[OW-1];
      if (cs_fall) begin
        active    <= 1'b1;
        cnt       <= '0;
        sho       <= load_word;
        frm_start <= 1'b1;
      end else if (cs_rise) begin
        active  <= 1'b0;
        frm_end <= active && (cnt == CNT_FULL);
        cnt     <= '0;
      end else if (active && ck_fall && (cnt != CNT_FULL)) begin
        shi <= {shi[FW-3:0], bit_in};
        sho <= {sho[OW-2:0], 1'b0};
        cnt <= cnt + 1'b1;
        if (cnt == CNT_MUX) mux_stb <= 1'b1;
        if (cnt == CNT_LAST) begin
          wr_stb  <= 1'b1;
          wr_word <= {shi, bit_in};
        end
      end
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_FULL);                                      // R2
  AST_WR_ON_LAST: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> cnt == CNT_FULL);                           // R2
  AST_MUX_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
    mux_stb |-> cnt == CNT_W'(ME));                        // R6
  AST_END_ONLY_FULL: assert property (@(posedge clk) disable iff (rst)
    frm_end |-> $past(cnt) == CNT_FULL);                   // R10
endmodule

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
  import adc_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_stb,
  input  logic [FRM_W-1:0] wr_word,
  input  logic             frm_start,
  input  logic             frm_end,
  input  logic             temp_done,
  input  logic [RES_W-1:0] conv_data,
  input  logic [CH_W-1:0]  cur_ch,
  output ctl_t             ctl,
  output logic             restart,
  output logic             busy,
  output logic [OUT_W-1:0] result
);
  ctl_t             nw;
  logic             pend;
  logic [TAG_W-1:0] ttag;

  always_comb nw = ctl_t'(wr_word[CTL_W-1:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl     <= '0;
      restart <= 1'b0;
      pend    <= 1'b0;
      busy    <= 1'b0;
      ttag    <= '0;
      result  <= '0;
    end else begin
      restart <= 1'b0;
      if (wr_stb && wr_word[FRM_W-1]) begin
        ctl     <= nw;
        restart <= 1'b1;
        pend    <= nw.tsense;
      end
      if (frm_start && pend) begin
        busy <= 1'b1;
        pend <= 1'b0;
        ttag <= ctl.avg ? TAG_TEMP_AVG : TAG_TEMP;
      end
      if (busy && temp_done) begin
        busy   <= 1'b0;
        result <= {ttag, conv_data};
      end else if (frm_end && !busy) begin
        result <= {1'b0, cur_ch, conv_data};
      end
    end
  end

  AST_HOLD_NO_WE: assert property (@(posedge clk) disable iff (rst)
    wr_stb && !wr_word[FRM_W-1] |=> $stable(ctl));         // R3
  AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(frm_start));                     // R8
  AST_BUSY_NEEDS_T: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(ctl.tsense));                    // R9
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
    busy && !temp_done |=> $stable(result));               // R8
endmodule

// File: rtl/adc_seq_sel.sv
module adc_seq_sel
  import adc_seq_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [CH_N-1:0] chmap,
  input  logic            rpt,
  input  logic            restart,
  input  logic            mux_stb,
  output logic [CH_W-1:0] cur
);
  logic [CH_N-1:0] order;
  logic [CH_W-1:0] first, nxt;
  logic            any, found, fresh;

  for (genvar g = 0; g < CH_N; g++) begin : g_order
    assign order[g] = chmap[CH_N-1-g];
  end

  always_comb begin
    first = cur;
    any   = 1'b0;
    nxt   = cur;
    found = 1'b0;
    for (int i = CH_N - 1; i >= 0; i--) begin
      if (order[i]) begin
        first = CH_W'(i);
        any   = 1'b1;
        if (i > int'(cur)) begin
          nxt   = CH_W'(i);
          found = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur   <= '0;
      fresh <= 1'b0;
    end else begin
      if (restart) fresh <= 1'b1;
      if (mux_stb) begin
        fresh <= 1'b0;
        if (any) begin
          if (fresh)      cur <= first;
          else if (found) cur <= nxt;
          else if (rpt)   cur <= first;
        end
      end
    end
  end

  AST_SEL_STEADY: assert property (@(posedge clk) disable iff (rst)
    !mux_stb |=> $stable(cur));                            // R6
  AST_SEL_IN_MAP: assert property (@(posedge clk) disable iff (rst)
    mux_stb && (|order) |=> order[cur]);                   // R5
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n,
  input  logic             sclk,
  input  logic             din,
  output logic             dout,
  input  logic [RES_W-1:0] conv_data,
  input  logic             temp_done,
  output logic [CH_W-1:0]  mux_sel,
  output logic             busy,
  output logic             ext_ref,
  output logic             pwr_down
);
  logic             frm_start, frm_end, wr_stb, mux_stb, restart;
  logic [FRM_W-1:0] wr_word;
  logic [OUT_W-1:0] result;
  ctl_t             ctl;

  adc_seq_spi u_spi (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .din(din),
    .load_word(result), .dout(dout), .frm_start(frm_start),
    .frm_end(frm_end), .wr_stb(wr_stb), .wr_word(wr_word),
    .mux_stb(mux_stb)
  );

  adc_seq_regs u_regs (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_word(wr_word),
    .frm_start(frm_start), .frm_end(frm_end), .temp_done(temp_done),
    .conv_data(conv_data), .cur_ch(mux_sel), .ctl(ctl),
    .restart(restart), .busy(busy), .result(result)
  );

  adc_seq_sel u_sel (
    .clk(clk), .rst(rst), .chmap(ctl.chmap), .rpt(ctl.rpt),
    .restart(restart), .mux_stb(mux_stb), .cur(mux_sel)
  );

  assign ext_ref  = ctl.ext_ref;
  assign pwr_down = ctl.ppd;
endmodule

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b1, sclk = 1'b1, din = 1'b0, temp_done = 1'b0;
  logic        dout, busy, ext_ref, pwr_down;
  logic [2:0]  mux_sel;
  logic [11:0] conv_data, tval = '0;
  logic        tmode = 1'b0;
  int nchk = 0, nfail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  function automatic logic [11:0] chv(input int c);
    return 12'h0A0 + 12'(c) * 12'h111;
  endfunction

  assign conv_data = tmode ? tval : chv(int'(mux_sel));

  adc_seq_ctrl dut_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .din(din),
    .dout(dout), .conv_data(conv_data), .temp_done(temp_done),
    .mux_sel(mux_sel), .busy(busy), .ext_ref(ext_ref), .pwr_down(pwr_down)
  );

  // behavioural model state
  bit m_rpt, m_ext, m_avg, m_ppd, m_pend, m_busy, m_fresh;
  bit [7:0] m_mask;
  int m_cur = 0;
  logic [3:0]  m_tag = '0, m_ttag = '0;
  logic [11:0] m_dat = '0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(bit we, bit rpt, bit [7:0] chs, bit t, bit ext, bit avg, bit ppd);
    logic [15:0] w;
    w[15] = we; w[14] = rpt;
    for (int c = 0; c < 8; c++) w[13-c] = chs[c];
    w[5] = t; w[4:3] = 2'b11; w[2] = ext; w[1] = avg; w[0] = ppd;
    return w;
  endfunction

  task automatic m_step();
    int first = -1, nxt = -1;
    for (int i = 0; i < 8; i++) if (m_mask[i] && first < 0) first = i;
    for (int i = 7; i >= 0; i--) if (m_mask[i] && i > m_cur) nxt = i;
    if (first >= 0) begin
      if (m_fresh) m_cur = first;
      else if (nxt >= 0) m_cur = nxt;
      else if (m_rpt) m_cur = first;
    end
    m_fresh = 0;
  endtask

  task automatic m_write(input logic [15:0] w);
    m_rpt = w[14];
    for (int c = 0; c < 8; c++) m_mask[c] = w[13-c];
    m_pend = w[5]; m_ext = w[2]; m_avg = w[1]; m_ppd = w[0];
    m_fresh = 1;
  endtask

  task automatic run_frame(input logic [15:0] w, input int nbits);
    logic [15:0] rd, expw;
    rd = '0;
    @(negedge clk) cs_n = 1'b0;
    if (m_pend) begin m_busy = 1; m_pend = 0; m_ttag = m_avg ? 4'd9 : 4'd8; end
    expw = {m_tag, m_dat};
    repeat (8) @(negedge clk);
    chk("R8", 32'(busy), 32'(m_busy), "busy after cs_n falls");
    for (int i = 0; i < nbits; i++) begin
      if (i < 16) rd[15-i] = dout;
      din = (i < 16) ? w[15-i] : ~w[i-16];
      repeat (4) @(negedge clk);
      sclk = 1'b0;
      repeat (8) @(negedge clk);
      if (i == 12) chk("R6", 32'(mux_sel), 32'(m_cur), "mux held after 13th edge");
      if (i == 13) begin m_step(); chk("R5", 32'(mux_sel), 32'(m_cur), "mux after 14th edge"); end
      if (i == 15 && w[15]) m_write(w);
      sclk = 1'b1;
      repeat (4) @(negedge clk);
    end
    cs_n = 1'b1; din = 1'b0;
    if (nbits >= 16 && !m_busy) begin m_tag = 4'(m_cur); m_dat = chv(m_cur); end
    repeat (8) @(negedge clk);
    if (nbits >= 16) chk("R7", 32'(rd), 32'(expw), "tagged word on dout");
    chk("R4", 32'(ext_ref), 32'(m_ext), "ext_ref field");
    chk("R4", 32'(pwr_down), 32'(m_ppd), "pwr_down field");
    chk("R6", 32'(mux_sel), 32'(m_cur), "mux after frame");
  endtask

  task automatic temp_finish(input logic [11:0] v);
    @(negedge clk) begin tmode = 1'b1; tval = v; temp_done = 1'b1; end
    @(negedge clk) begin temp_done = 1'b0; tmode = 1'b0; end
    if (m_busy) begin m_tag = m_ttag; m_dat = v; m_busy = 0; end
    repeat (2) @(negedge clk);
    chk("R8", 32'(busy), 32'(m_busy), "busy falls on temp_done");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1", 32'(dout), 0, "dout");
    chk("R1", 32'(busy), 0, "busy");
    chk("R1", 32'(mux_sel), 0, "mux_sel");
    chk("R1", 32'(ext_ref), 0, "ext_ref");
    chk("R1", 32'(pwr_down), 0, "pwr_down");

    run_frame(mk(1, 0, 8'h00, 0, 1, 0, 1), 16);        // R4 ext_ref and ppd set
    run_frame(mk(0, 1, 8'hFF, 1, 0, 1, 0), 16);        // R3 write disabled
    chk("R3", 32'(ext_ref), 1, "ext_ref kept without write enable");
    chk("R11", 32'(pwr_down), 1, "power-down retained");
    chk("R3", 32'(busy), 0, "no temperature started without write enable");

    // channels 1,3,6 with repeat: wrap 6 -> 1
    run_frame(mk(1, 1, 8'b0100_1010, 0, 0, 0, 1), 16);
    for (int k = 0; k < 5; k++) run_frame(16'h0000, 16);
    chk("R11", 32'(pwr_down), 1, "power-down held over many frames");

    // R10 aborted write frame
    run_frame(mk(1, 0, 8'h00, 0, 1, 0, 0), 10);
    chk("R10", 32'(pwr_down), 1, "aborted frame leaves register");
    chk("R10", 32'(ext_ref), 0, "aborted frame leaves register");
    run_frame(16'h0000, 16);                           // R10 counter restarted

    // R2 20-edge frame: channels 2,4, no repeat
    run_frame(mk(1, 0, 8'b0001_0100, 0, 0, 0, 0), 20);
    chk("R2", 32'(pwr_down), 0, "first 16 bits only");
    for (int k = 0; k < 3; k++) run_frame(16'h0000, 16);   // R5 hold on 4

    // R8 temperature
    run_frame(mk(1, 0, 8'b0001_0100, 1, 0, 0, 0), 16);
    run_frame(16'h0000, 16);
    chk("R8", 32'(busy), 1, "busy held until done");
    temp_finish(12'h5A5);
    run_frame(16'h0000, 16);

    // R9 averaging alone
    run_frame(mk(1, 0, 8'b0001_0100, 0, 0, 1, 0), 16);
    run_frame(16'h0000, 16);
    chk("R9", 32'(busy), 0, "averaging alone starts nothing");

    // averaged temperature, tag 9
    run_frame(mk(1, 0, 8'b0001_0100, 1, 0, 1, 1), 16);
    run_frame(16'h0000, 16);
    temp_finish(12'h3C3);
    run_frame(mk(1, 0, 8'h00, 0, 0, 0, 0), 16);
    chk("R11", 32'(pwr_down), 0, "cleared by writing bit 0 low");
    run_frame(16'h0000, 16);

    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule